// File: doc/BRIEF.md
# Power-Fail Memory Access Guard

This block sits between a host bus-cycle decoder and a static RAM and decides, clock by clock, whether the host's chip, write and output strobes reach the memory. All inputs are asynchronous, so each one passes through a two-flop synchroniser. The supply-good flag and two battery-good flags come from external comparators.

While the supply is below its operating threshold, every access is dropped. When the supply returns, the two battery flags are sampled once. If both cells report low, the second memory cycle after power-up is silently suppressed. Software can therefore find a dead battery by reading a location, writing a new value to it, and reading it back: the write never lands.

A memory cycle opens on each falling edge of the synchronised chip enable. The block counts these openings from power-up and saturates the count. A fall of the supply flag clears both the count and the stored battery result, so the check runs again on every restore.

Top module: `pf_access_guard`

## Requirements
- R1: While the synchronised supply flag is low, mem_ce_no, mem_we_no and mem_oe_no are all high and drv_en_o is low.
- R2: If both battery flags are low when the supply flag rises, the whole of the second cycle after the rise is blocked. Cycle number 2 is the second chip-enable fall after the rise. While it is blocked, all outputs are inactive.
- R3: If at least one battery flag is high at the rise, no cycle is blocked. Battery flags that change after the rise have no effect until the next restore.
- R4: Cycle 1 and every cycle from 3 onwards pass normally, including when a low battery was recorded.
- R5: A supply fall clears the cycle count and the battery result. The next restore repeats the check with the battery flags present at that time.
- R6: mem_we_no is low exactly while chip enable and write enable are both low. It therefore opens at the later of the two falls and closes at the earlier of the two rises.
- R7: mem_oe_no is low while chip enable is low and write enable is high (a read). mem_ce_no is low while chip enable is low.
- R8: drv_en_o is high only while chip enable and output enable are low and write enable is high. A write-enable fall turns the drivers off.
- R9: Each output reflects an input change after exactly three rising clock edges: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above operating threshold |
| batt_a_ok_i | input | 1 | Cell A above warning threshold |
| batt_b_ok_i | input | 1 | Cell B above warning threshold |
| ce_ni | input | 1 | Host chip enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| oe_ni | input | 1 | Host output enable, active low |
| mem_ce_no | output | 1 | Gated memory chip enable, active low |
| mem_we_no | output | 1 | Gated memory write enable, active low |
| mem_oe_no | output | 1 | Gated memory read enable, active low |
| drv_en_o | output | 1 | Host data driver enable, active high |

## Verification
Every output is due on the third rising edge after an input change. The bench therefore changes inputs on a falling edge, lets three rising edges pass, and samples on the next falling edge. One check samples after only two edges to confirm that the old value still holds. Supply and battery changes obey the same three-edge rule, so the bench's cycle-count model advances only at those settled points. The bench sweeps all four battery combinations, walks each through four cycles with every write/output-enable combination inside each cycle, and repeats across restores.

// File: rtl/pf_guard_pkg.sv
package pf_guard_pkg;
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

  function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] max);
    return (v >= max) ? max : v + 8'd1;
  endfunction
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      chain_q[s] <= RST_VAL;
      else if (s == 0)  chain_q[s] <= d_i;
      else              chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pf_restore_check.sv
module pf_restore_check
  import pf_guard_pkg::*;
#(
  parameter int NBATT     = 2,
  parameter int BLOCK_IDX = 2,
  parameter int CNT_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sup_s_i,
  input  logic [NBATT-1:0] batt_ok_s_i,
  input  logic             ce_s_i,
  output logic             blk_o
);
  localparam logic [7:0] CNT_MAX = 8'((1 << CNT_W) - 1);

  logic             sup_d, ce_d;
  logic             batt_low_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc, idx;
  logic             sup_rise, ce_fall, all_low;

  assign sup_rise = sup_s_i & ~sup_d;
  assign ce_fall  = ce_d & ~ce_s_i;
  // warning only when every cell is low
  assign all_low  = ~|batt_ok_s_i;
  assign cnt_inc  = CNT_W'(sat_inc(8'(cnt_q), CNT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sup_d      <= 1'b0;
      ce_d       <= 1'b1;
      cnt_q      <= '0;
      batt_low_q <= 1'b0;
    end else begin
      sup_d <= sup_s_i;
      ce_d  <= ce_s_i;
      if (sup_rise) begin
        cnt_q      <= '0;
        batt_low_q <= all_low;
      end else if (!sup_s_i) begin
        cnt_q      <= '0;
        batt_low_q <= 1'b0;
      end else if (ce_fall) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  // index of the cycle in progress, including one opening right now
  assign idx   = (ce_fall && !sup_rise) ? cnt_inc : cnt_q;
  assign blk_o = batt_low_q & sup_s_i & ~sup_rise & (idx == CNT_W'(BLOCK_IDX));
endmodule

// File: rtl/pf_strobe_gate.sv
module pf_strobe_gate
  import pf_guard_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t st_i,
  input  logic    pass_i,
  output logic    mem_ce_no,
  output logic    mem_we_no,
  output logic    mem_oe_no,
  output logic    drv_en_o
);
  logic sel, wr, rd, drv;

  assign sel = ~st_i.ce_n & pass_i;
  assign wr  = sel & ~st_i.we_n;
  assign rd  = sel &  st_i.we_n;
  assign drv = rd  & ~st_i.oe_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce_no <= 1'b1;
      mem_we_no <= 1'b1;
      mem_oe_no <= 1'b1;
      drv_en_o  <= 1'b0;
    end else begin
      mem_ce_no <= ~sel;
      mem_we_no <= ~wr;
      mem_oe_no <= ~rd;
      drv_en_o  <= drv;
    end
  end
endmodule

// File: rtl/pf_access_guard.sv
module pf_access_guard
  import pf_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BLOCK_IDX   = 2,
  parameter int CNT_W       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic batt_a_ok_i,
  input  logic batt_b_ok_i,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic mem_ce_no,
  output logic mem_we_no,
  output logic mem_oe_no,
  output logic drv_en_o
);
  localparam int NBATT = 2;
  localparam int SW    = 1 + NBATT + $bits(strobe_t);
  localparam logic [SW-1:0] SYNC_RST = {1'b0, {NBATT{1'b1}}, STROBE_IDLE};

  logic [SW-1:0]    raw, synced;
  logic             sup_s, we_s, blk;
  logic [NBATT-1:0] batt_s;
  strobe_t          st_s;

  assign raw = {supply_ok_i, batt_a_ok_i, batt_b_ok_i, ce_ni, we_ni, oe_ni};

  pf_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(synced)
  );

  assign {sup_s, batt_s, st_s} = synced;
  assign we_s = st_s.we_n;

  pf_restore_check #(.NBATT(NBATT), .BLOCK_IDX(BLOCK_IDX), .CNT_W(CNT_W)) u_check (
    .clk_i, .rst_ni, .sup_s_i(sup_s), .batt_ok_s_i(batt_s), .ce_s_i(st_s.ce_n), .blk_o(blk)
  );

  pf_strobe_gate u_gate (
    .clk_i, .rst_ni, .st_i(st_s), .pass_i(sup_s & ~blk),
    .mem_ce_no, .mem_we_no, .mem_oe_no, .drv_en_o
  );
endmodule

// File: rtl/pf_access_guard_chk.sv
module pf_access_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sup_s,
  input logic we_s,
  input logic mem_ce_no,
  input logic mem_we_no,
  input logic mem_oe_no,
  input logic drv_en_o
);
  AST_DEAD_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_s |=> (mem_ce_no && mem_we_no && mem_oe_no && !drv_en_o)); // R1
  AST_WE_HIGH_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_s |=> mem_we_no); // R6
  AST_WRITE_IN_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no); // R6
  AST_READ_IN_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (mem_we_no && !mem_ce_no)); // R7
  AST_DRIVE_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> (mem_we_no && !mem_oe_no)); // R8
endmodule

bind pf_access_guard pf_access_guard_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sup_s(sup_s), .we_s(we_s),
  .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no), .drv_en_o(drv_en_o)
);

// File: tb/pf_access_guard_test.sv
module pf_access_guard_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sup = 1'b0, ba = 1'b1, bb = 1'b1, ce = 1'b1, we = 1'b1, oe = 1'b1;
  logic mem_ce_no, mem_we_no, mem_oe_no, drv_en_o;
  int checks = 0, errors = 0;

  // bench model
  logic m_sup = 1'b0, m_ce = 1'b1, m_low = 1'b0;
  int   m_idx = 0;

  always #2 clk = ~clk;

  pf_access_guard uut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(sup), .batt_a_ok_i(ba), .batt_b_ok_i(bb),
    .ce_ni(ce), .we_ni(we), .oe_ni(oe),
    .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no), .drv_en_o(drv_en_o)
  );

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {mem_ce_no, mem_we_no, mem_oe_no, drv_en_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic s, a, b, c, w, o, input string scen);
    logic blk, en;
    logic [3:0] exp;
    string tag;
    sup = s; ba = a; bb = b; ce = c; we = w; oe = o;
    if (s && !m_sup) begin m_low = !a && !b; m_idx = 0; end
    else if (!s)     begin m_low = 1'b0; m_idx = 0; end
    else if (!c && m_ce) m_idx = (m_idx >= 3) ? 3 : m_idx + 1;
    m_sup = s; m_ce = c;
    blk = m_low && s && (m_idx == 2);
    en  = s && !blk;
    exp = {!(!c && en), !(!c && !w && en), !(!c && w && en), !c && !o && w && en};
    if (!s)            tag = "R1";
    else if (blk)      tag = "R2";
    else if (!c && !w) tag = "R6";
    else if (!c && !o) tag = "R8";
    else if (!c)       tag = "R7";
    else               tag = scen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic session(input logic a, b, input string scen);
    apply(1, a, b, 1, 1, 1, scen);
    for (int cyc = 0; cyc < 4; cyc++) begin
      if (cyc == 3) apply(1, a, b, 1, 0, 1, "R6"); // write strobe before chip enable
      apply(1, a, b, 0, (cyc == 3) ? 1'b0 : 1'b1, 1, scen);
      apply(1, a, b, 0, 1, 0, scen);
      apply(1, a, b, 0, 0, 0, scen);
      apply(1, a, b, 0, 0, 1, scen);
      apply(1, a, b, 0, 1, 1, scen);
      apply(1, a, b, 1, 1, 1, scen);
    end
    apply(1, 0, 0, 0, 1, 0, "R3"); // cells fall after restore: no effect
    apply(0, 0, 0, 0, 1, 0, "R1");
    apply(0, a, b, 1, 1, 1, "R1");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(4'b1110, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    apply(0, 1, 1, 0, 1, 0, "R1");
    apply(0, 1, 1, 1, 1, 1, "R1");
    for (int k = 0; k < 4; k++)
      session(k[1], k[0], (k == 0) ? "R4" : "R3");
    session(1, 1, "R5");
    session(0, 0, "R4");
    session(0, 1, "R5");
    // R9: two edges after a read request the outputs still show idle
    sup = 1'b1; ba = 1'b1; bb = 1'b1; ce = 1'b1; we = 1'b1; oe = 1'b1;
    m_sup = 1'b1; m_low = 1'b0; m_idx = 0; m_ce = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    ce = 1'b0; oe = 1'b0; m_ce = 1'b0; m_idx = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(4'b1110, "R9");
    @(posedge clk);
    @(negedge clk);
    check(4'b0101, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule